// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block steers device interrupt lines to a small set of processors. One request register, shared by every processor, records which device lines are asserted. Each line is set or cleared through a strobe that carries its line number. Each processor has its own enable mask. The block keeps a routed register per processor that always equals that processor's mask ANDed with the shared request register.

Each processor has one level-sensitive interrupt output. The output is high whenever the processor's routed register is nonzero. Software programs the masks and reads back masks, routed values and the request register through a 64-bit register port. Register slots are spaced 64 bytes apart, so the slot number is the byte offset shifted right by six.

The slot layout is as follows. Slots 0 to NUM_CPU-1 hold the masks. Slots NUM_CPU to 2*NUM_CPU-1 hold the routed registers. Slot 2*NUM_CPU holds the request register. Any malformed access sets a sticky error flag. Such an access changes no register, and a read returns zero.

Top module: `dev_irq_router`

## Requirements
- R1: After reset, every mask, routed and request bit is zero, every `cpu_irq` bit is low and `reg_err` is low.
- R2: A write with `reg_size` = 8 to slot k (byte offset 64*k, k < NUM_CPU) stores `reg_wdata` into CPU k's mask. A read of that slot returns the value on `reg_rdata` on the clock edge that accepts the read.
- R3: The routed register of CPU k, read at slot NUM_CPU+k, always equals mask[k] AND the request register. The request register reads at slot 2*NUM_CPU.
- R4: A `line_set_vld` strobe sets request bit `line_set_idx`. The routed register of every CPU whose mask has that bit set then shows it.
- R5: A `line_clr_vld` strobe clears request bit `line_clr_idx` only if that bit is set. A clear for a line that is not pending leaves the request register unchanged.
- R6: `cpu_irq[k]` is the OR of all bits of CPU k's routed register. It follows the routed register one clock later.
- R7: When a mask write and a line set arrive in the same cycle, the mask write is applied first. The routed value then includes the new line wherever the new mask enables it.
- R8: When a set and a clear name the same line in the same cycle, the set wins and the line stays pending.
- R9: The following accesses set the sticky `reg_err` flag, which only reset clears: a write to a routed or request slot, any access whose `reg_size` is not 8, and any access to a slot above 2*NUM_CPU. Such a write changes no register, and such a read returns zero.
- R10: Address bits below bit 6 are ignored, so any byte offset inside a 64-byte slot reaches the same register.
- R11: A mask write raises `cpu_irq[k]` when it enables a line that is already pending. A mask write lowers `cpu_irq[k]` when it removes the last routed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_set_vld | input | 1 | Strobe: assert one device line |
| line_set_idx | input | $clog2(NUM_LINES) | Line number to assert |
| line_clr_vld | input | 1 | Strobe: deassert one device line |
| line_clr_idx | input | $clog2(NUM_LINES) | Line number to deassert |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_size | input | 4 | Access size in bytes; only 8 is legal |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_err | output | 1 | Sticky malformed-access flag |
| cpu_irq | output | NUM_CPU | Per-CPU level interrupt |

## Verification
Some behaviours are checked by assertions on every cycle:
- each routed register matches its mask ANDed with the request register;
- a set strobe leaves its line pending;
- a clear for a line that is not pending leaves the request register steady;
- an interrupt output rises or falls only after its routed register has turned nonzero or zero;
- the error flag never drops;
- a rejected read returns zero.

Other behaviours can only be shown by the bench's scenarios:
- the slot layout and the address bits that are ignored;
- the one-cycle delay of the interrupt outputs;
- the ordering of a mask write and a line set in the same cycle;
- a set winning over a clear of the same line;
- the fact that rejected writes are discarded.

// File: rtl/dir_pkg.sv
// Package: shared constants and types for the device interrupt router.
// Assumes a 64-bit register port with register slots spaced 64 bytes apart.
package dir_pkg;
    localparam int WORD_W       = 64;   // register width
    localparam int SLOT_LSB     = 6;    // slot = byte offset >> 6
    localparam int ACCESS_BYTES = 8;    // only full-word accesses are legal

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dir_pending.sv
// Module: shared request register.
// Turns the set and clear strobes into bit masks and keeps the request bits.
// A clear only acts on a line that is pending. A set of the same line in the
// same cycle wins over the clear. Also exports the next-state value so that
// the per-CPU slices can update in the same cycle.
module dir_pending #(
    parameter int NUM_LINES = 64,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld,
    input  logic [LINE_W-1:0]    set_idx,
    input  logic                 clr_vld,
    input  logic [LINE_W-1:0]    clr_idx,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] pend_nxt
);
    logic [NUM_LINES-1:0] set_bits;
    logic [NUM_LINES-1:0] clr_bits;

    // Decode the strobes; a clear keeps only the bit that is currently pending.
    always_comb begin
        set_bits = '0;
        clr_bits = '0;
        if (set_vld) set_bits[set_idx] = 1'b1;
        if (clr_vld) clr_bits[clr_idx] = pend_q[clr_idx];
        pend_nxt = (pend_q & ~clr_bits) | set_bits;
    end

    // Hold the request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // R4
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> pend_q[$past(set_idx)]);

    // R5
    spur_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !set_vld && !pend_q[clr_idx]) |=> $stable(pend_q));
endmodule

// File: rtl/dir_cpu_slice.sv
// Module: per-processor state.
// Holds the mask register, the routed register (mask AND requests) and the
// registered interrupt level. A mask write lands first, and the routed
// register is then rebuilt from the new mask and the next request value.
// That order makes a same-cycle mask write and line set both visible.
module dir_cpu_slice #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] pend_nxt,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] routed_q,
    output logic                 irq_q
);
    logic [NUM_LINES-1:0] mask_nxt;

    // Apply the mask write ahead of the request update.
    always_comb mask_nxt = mask_we ? mask_wdata : mask_q;

    // Keep the mask and rebuild the routed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            routed_q <= '0;
        end else begin
            mask_q   <= mask_nxt;
            routed_q <= mask_nxt & pend_nxt;
        end
    end

    // Interrupt level: follows the routed register one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |routed_q;
    end

    // R3
    routed_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        routed_q == (mask_q & pend_q));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(routed_q != '0));

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(routed_q == '0));
endmodule

// File: rtl/dir_regif.sv
// Module: register port decode.
// Maps the slot number (byte offset >> 6) to the masks, routed registers and
// request register, and produces per-CPU mask write enables. It registers
// the read data and keeps a sticky error flag for malformed accesses.
// Assumes reg_wr and reg_rd are not both high in the same cycle.
module dir_regif #(
    parameter int NUM_CPU   = 4,
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [3:0]                        reg_size,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0] routed_q,
    input  logic [NUM_LINES-1:0]              pend_q,
    output logic [NUM_CPU-1:0]                mask_we,
    output dir_pkg::word_t                    rdata_q,
    output logic                              err_q
);
    import dir_pkg::*;

    localparam int SLOT_W = ADDR_W - SLOT_LSB;
    localparam logic [SLOT_W-1:0] ROUTED_BASE = SLOT_W'(NUM_CPU);
    localparam logic [SLOT_W-1:0] PEND_SLOT   = SLOT_W'(2 * NUM_CPU);

    logic [SLOT_W-1:0]  slot;
    logic [SLOT_LSB-1:0] addr_lo_unused;
    logic               size_ok;
    logic               is_mask;
    logic               is_routed;
    logic               is_pend;
    logic               bad;
    word_t              sel;

    // Split the address and classify the access.
    always_comb begin
        slot           = reg_addr[ADDR_W-1:SLOT_LSB];
        addr_lo_unused = reg_addr[SLOT_LSB-1:0];
        size_ok        = (reg_size == 4'(ACCESS_BYTES));
        is_mask        = (slot < ROUTED_BASE);
        is_routed      = (slot >= ROUTED_BASE) && (slot < PEND_SLOT);
        is_pend        = (slot == PEND_SLOT);
        bad            = (reg_wr || reg_rd) &&
                         (!size_ok || !(is_mask || is_routed || is_pend) ||
                          (reg_wr && !is_mask));
    end

    // Per-CPU mask write enables, one per slot.
    generate
        for (genvar k = 0; k < NUM_CPU; k++) begin : g_we
            assign mask_we[k] = reg_wr && size_ok && (slot == SLOT_W'(k));
        end
    endgenerate

    // Read multiplexer over all readable slots.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_CPU; k++) begin
            if (slot == SLOT_W'(k))           sel = WORD_W'(mask_q[k]);
            if (slot == SLOT_W'(NUM_CPU + k)) sel = WORD_W'(routed_q[k]);
        end
        if (is_pend) sel = WORD_W'(pend_q);
    end

    // Register the read data; a rejected read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (reg_rd && !bad)   rdata_q <= sel;
        else if (reg_rd)           rdata_q <= '0;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && bad) |=> (rdata_q == '0) && err_q);
endmodule

// File: rtl/dev_irq_router.sv
// Module: top of the per-CPU device interrupt router.
// Connects the shared request register, one slice per CPU and the register
// port decode. Assumes NUM_LINES is at most the 64-bit register width.
module dev_irq_router #(
    parameter int NUM_CPU   = 4,
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_set_vld,
    input  logic [LINE_W-1:0]    line_set_idx,
    input  logic                 line_clr_vld,
    input  logic [LINE_W-1:0]    line_clr_idx,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [3:0]           reg_size,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    output logic                 reg_err,
    output logic [NUM_CPU-1:0]   cpu_irq
);
    logic [NUM_LINES-1:0]              pend_q;
    logic [NUM_LINES-1:0]              pend_nxt;
    logic [NUM_CPU-1:0]                mask_we;
    logic [NUM_CPU-1:0][NUM_LINES-1:0] mask_q;
    logic [NUM_CPU-1:0][NUM_LINES-1:0] routed_q;

    dir_pending #(.NUM_LINES(NUM_LINES)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (line_set_vld),
        .set_idx  (line_set_idx),
        .clr_vld  (line_clr_vld),
        .clr_idx  (line_clr_idx),
        .pend_q   (pend_q),
        .pend_nxt (pend_nxt)
    );

    generate
        for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
            dir_cpu_slice #(.NUM_LINES(NUM_LINES)) u_slice (
                .clk        (clk),
                .rst_n      (rst_n),
                .mask_we    (mask_we[k]),
                .mask_wdata (reg_wdata[NUM_LINES-1:0]),
                .pend_q     (pend_q),
                .pend_nxt   (pend_nxt),
                .mask_q     (mask_q[k]),
                .routed_q   (routed_q[k]),
                .irq_q      (cpu_irq[k])
            );
        end
    endgenerate

    dir_regif #(
        .NUM_CPU   (NUM_CPU),
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_size (reg_size),
        .mask_q   (mask_q),
        .routed_q (routed_q),
        .pend_q   (pend_q),
        .mask_we  (mask_we),
        .rdata_q  (reg_rdata),
        .err_q    (reg_err)
    );
endmodule

// File: tb/dev_irq_router_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; each task checks its own results.
module dev_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_set_vld = 1'b0;
    logic [5:0]  line_set_idx = '0;
    logic        line_clr_vld = 1'b0;
    logic [5:0]  line_clr_idx = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dev_irq_router u_dev_irq_router (
        .clk(clk), .rst_n(rst_n),
        .line_set_vld(line_set_vld), .line_set_idx(line_set_idx),
        .line_clr_vld(line_clr_vld), .line_clr_idx(line_clr_idx),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_set_vld = 1'b0; line_clr_vld = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_size = 4'd8;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [11:0] addr, input logic [63:0] data, input logic [3:0] size);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data; reg_size = size;
        tick();
        reg_wr = 1'b0; reg_size = 4'd8;
    endtask

    task automatic rd(input logic [11:0] addr, input logic [3:0] size, output logic [63:0] data);
        reg_rd = 1'b1; reg_addr = addr; reg_size = size;
        tick();
        data = reg_rdata;
        reg_rd = 1'b0; reg_size = 4'd8;
    endtask

    task automatic set_line(input int n);
        line_set_vld = 1'b1; line_set_idx = 6'(n);
        tick();
        line_set_vld = 1'b0;
    endtask

    task automatic clr_line(input int n);
        line_clr_vld = 1'b1; line_clr_idx = 6'(n);
        tick();
        line_clr_vld = 1'b0;
    endtask

    // Slot k sits at byte offset 64*k: masks 0..3, routed 4..7, requests 8.
    task automatic t_reset();
        logic [63:0] v;
        check("R1 irq", 64'(cpu_irq), 64'h0);
        check("R1 err", 64'(reg_err), 64'h0);
        rd(12'd512, 4'd8, v); check("R1 pending", v, 64'h0);
        rd(12'd192, 4'd8, v); check("R1 mask3", v, 64'h0);
        rd(12'd384, 4'd8, v); check("R1 routed2", v, 64'h0);
    endtask

    task automatic t_mask_rw();
        logic [63:0] v;
        wr(12'd0, 64'hDEAD_BEEF_0123_4567, 4'd8);
        wr(12'd64 + 12'h28, 64'h8000_0000_0000_0001, 4'd8);  // R10 offset inside slot 1
        rd(12'd0, 4'd8, v);  check("R2 mask0 readback", v, 64'hDEAD_BEEF_0123_4567);
        rd(12'd64, 4'd8, v); check("R10 mask1 via inner offset", v, 64'h8000_0000_0000_0001);
        rd(12'd120, 4'd8, v); check("R10 mask1 read inner offset", v, 64'h8000_0000_0000_0001);
        check("R2 no irq without requests", 64'(cpu_irq), 64'h0);
        check("R2 no error", 64'(reg_err), 64'h0);
    endtask

    task automatic t_route();
        logic [63:0] v;
        wr(12'd0,   (64'h1 << 5) | (64'h1 << 63), 4'd8);
        wr(12'd64,  64'h1 << 7, 4'd8);
        wr(12'd128, 64'h0, 4'd8);
        wr(12'd192, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
        set_line(5);
        check("R6 irq not yet raised", 64'(cpu_irq), 64'h0);
        tick();
        check("R6 irq one cycle later", 64'(cpu_irq), 64'h9);
        rd(12'd256, 4'd8, v); check("R3 routed0", v, 64'h1 << 5);
        rd(12'd448, 4'd8, v); check("R3 routed3", v, 64'h1 << 5);
        rd(12'd320, 4'd8, v); check("R3 routed1 empty", v, 64'h0);
        rd(12'd512, 4'd8, v); check("R4 pending line5", v, 64'h1 << 5);
        set_line(63);
        rd(12'd256, 4'd8, v); check("R4 routed0 line63", v, (64'h1 << 5) | (64'h1 << 63));
    endtask

    task automatic t_clear();
        logic [63:0] v;
        clr_line(7);
        rd(12'd512, 4'd8, v); check("R5 spurious clear ignored", v, (64'h1 << 5) | (64'h1 << 63));
        check("R5 irq1 stays low", 64'(cpu_irq), 64'h9);
        clr_line(5);
        rd(12'd256, 4'd8, v); check("R5 routed0 after clear", v, 64'h1 << 63);
        check("R6 irq held by line63", 64'(cpu_irq), 64'h9);
        clr_line(63);
        tick();
        check("R6 irq dropped", 64'(cpu_irq), 64'h0);
        rd(12'd512, 4'd8, v); check("R5 pending empty", v, 64'h0);
    endtask

    task automatic t_mask_change();
        set_line(10);
        tick();
        check("R11 cpu2 masked off", 64'(cpu_irq[2]), 64'h0);
        wr(12'd128, 64'h1 << 10, 4'd8);
        tick();
        check("R11 mask enables pending line", 64'(cpu_irq[2]), 64'h1);
        wr(12'd128, 64'h0, 4'd8);
        tick();
        check("R11 mask removes routing", 64'(cpu_irq[2]), 64'h0);
        check("R11 cpu3 unaffected", 64'(cpu_irq[3]), 64'h1);
    endtask

    task automatic t_same_cycle();
        logic [63:0] v;
        do_reset();
        reg_wr = 1'b1; reg_addr = 12'd64; reg_wdata = 64'h1 << 20;
        line_set_vld = 1'b1; line_set_idx = 6'd20;
        tick();
        reg_wr = 1'b0; line_set_vld = 1'b0;
        rd(12'd320, 4'd8, v); check("R7 routed1 has both", v, 64'h1 << 20);
        check("R7 irq1 raised", 64'(cpu_irq), 64'h2);
    endtask

    task automatic t_set_clr();
        logic [63:0] v;
        line_set_vld = 1'b1; line_set_idx = 6'd20;
        line_clr_vld = 1'b1; line_clr_idx = 6'd20;
        tick();
        line_set_vld = 1'b0; line_clr_vld = 1'b0;
        rd(12'd512, 4'd8, v); check("R8 set wins over clear", v, 64'h1 << 20);
        line_set_vld = 1'b1; line_set_idx = 6'd0;
        line_clr_vld = 1'b1; line_clr_idx = 6'd0;
        tick();
        line_set_vld = 1'b0; line_clr_vld = 1'b0;
        rd(12'd512, 4'd8, v); check("R8 set wins on fresh line", v, (64'h1 << 20) | 64'h1);
    endtask

    task automatic t_errors();
        logic [63:0] v;
        do_reset();
        set_line(3);
        wr(12'd512, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
        check("R9 err on request write", 64'(reg_err), 64'h1);
        rd(12'd512, 4'd8, v); check("R9 request write discarded", v, 64'h1 << 3);
        do_reset();
        wr(12'd0, 64'h00FF, 4'd4);
        check("R9 err on short write", 64'(reg_err), 64'h1);
        rd(12'd0, 4'd8, v); check("R9 short write discarded", v, 64'h0);
        do_reset();
        wr(12'd256, 64'h1, 4'd8);
        check("R9 err on routed write", 64'(reg_err), 64'h1);
        tick();
        check("R9 err sticky", 64'(reg_err), 64'h1);
        do_reset();
        wr(12'd0, 64'h2, 4'd8);
        set_line(1);
        rd(12'd256, 4'd4, v); check("R9 short read returns zero", v, 64'h0);
        check("R9 err on short read", 64'(reg_err), 64'h1);
        do_reset();
        rd(12'd1280, 4'd8, v); check("R9 unmapped read zero", v, 64'h0);
        check("R9 err on unmapped", 64'(reg_err), 64'h1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_mask_rw();
        t_route();
        t_clear();
        t_mask_change();
        t_same_cycle();
        t_set_clr();
        t_errors();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule